// File: doc/BRIEF.md
# Ping-pong audio DMA pointer controller

This block is the memory side of an audio serial port. Software writes a transmit buffer pointer, a receive buffer pointer and one buffer length that both directions share, then issues a start command. On every frame tick the block reads one 32-bit word from the transmit buffer and presents it to the serial side. It also writes the word that the serial side captured on that tick into the receive buffer. All memory traffic goes through a simple request/acknowledge port.

A pointer and a length are taken over whenever a buffer begins. Each direction then raises its own pointer-taken event, and software is free to queue the next buffer while the current one streams. If no new pointer was written, the same buffer plays again. A stop command halts streaming between words and raises a stopped event. The three events are combined with an interrupt mask into one level interrupt.

Top module: `apdma_ptr_ctrl`

## Requirements
- R1: A write to the transmit pointer (address 0) or the receive pointer (address 1) whose data has bits [1:0] not zero is ignored, and the earlier pointer is kept. Every memory address the block issues is word aligned.
- R2: The length register (address 2) takes a byte count. A write is ignored when the count is zero, is not a multiple of 4, or exceeds 4*(2^CNT_W-1) bytes. An accepted write sets the buffer length in words.
- R3: A write to address 4 while idle starts streaming. Each direction enabled in address 3 (bit 0 transmit, bit 1 receive) takes its written pointer, and the length is taken at the same time. The pointer-taken event of each enabled direction is raised (event bit 0 transmit, bit 1 receive).
- R4: Each frame tick while streaming does the following for word index i of the buffer. With transmit active, it first reads pointer+4*i and drives the read data on tx_word_o with a one-cycle tx_word_vld_o pulse. With receive active, it then writes rx_word_i, sampled at the tick, to pointer+4*i.
- R5: After the last word of a buffer, the index returns to 0 and the length is taken again. Each enabled direction takes the most recently written pointer, which replays the same buffer when nothing new was written, and its pointer-taken event is raised.
- R6: An event bit stays set until a write of 0 to its clear address: 6 for transmit, 7 for receive, 8 for stopped. A write of a nonzero value there has no effect.
- R7: A write to address 9 sets the interrupt mask bits given in data bits [2:0]. A write to address 10 clears them. irq_o is high exactly when some event bit and its mask bit are both set.
- R8: A write to address 5 stops streaming at the next word boundary and raises the stopped event (bit 2). After that, frame ticks issue no memory requests.
- R9: A direction disabled mid-buffer finishes its current buffer. It then raises a final pointer-taken event and issues no more memory requests.
- R10: After reset there are no memory requests, all events and mask bits are clear, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| frame_tick_i | input | 1 | One word slot per direction |
| rx_word_i | input | 32 | Received word, sampled at the tick |
| tx_word_o | output | 32 | Word fetched for transmission |
| tx_word_vld_o | output | 1 | Pulse when tx_word_o is updated |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| ev_o | output | 3 | Events: transmit, receive, stopped |
| irq_o | output | 1 | Masked level interrupt |

## Verification
The hardest case to reach is a buffer boundary where the two directions disagree. Transmit has been disabled mid-buffer while receive continues, a new pointer is queued for only one direction, and rejected pointer and length writes have been left in between. The stimulus builds exactly this state with a short buffer limit (CNT_W=4). It follows the boundary with ticks that must yield receive writes only, at replayed addresses, and a reference model predicts every memory transaction address, direction and data.

// File: rtl/apdma_pkg.sv
package apdma_pkg;
  localparam logic [3:0] A_TXPTR = 4'd0;
  localparam logic [3:0] A_RXPTR = 4'd1;
  localparam logic [3:0] A_LEN = 4'd2;
  localparam logic [3:0] A_EN = 4'd3;
  localparam logic [3:0] A_START = 4'd4;
  localparam logic [3:0] A_STOP = 4'd5;
  localparam logic [3:0] A_CLR_TX = 4'd6;
  localparam logic [3:0] A_CLR_RX = 4'd7;
  localparam logic [3:0] A_CLR_STOP = 4'd8;
  localparam logic [3:0] A_MSET = 4'd9;
  localparam logic [3:0] A_MCLR = 4'd10;

  localparam int unsigned EV_TX = 0;
  localparam int unsigned EV_RX = 1;
  localparam int unsigned EV_STOP = 2;
  localparam int unsigned N_EV = 3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD, S_WR, S_ADV} seq_state_e;
endpackage

// File: rtl/apdma_cfg_regs.sv
module apdma_cfg_regs
  import apdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [ADDR_W-1:0] tx_ptr_o,
  output logic [ADDR_W-1:0] rx_ptr_o,
  output logic [CNT_W-1:0]  len_words_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              start_o,
  output logic              stop_o,
  output logic [N_EV-1:0]   ev_clr_o,
  output logic [N_EV-1:0]   mask_set_o,
  output logic [N_EV-1:0]   mask_clr_o
);
  logic ptr_ok, len_ok;

  assign ptr_ok = (wdata_i[1:0] == 2'b00);
  // byte count: multiple of 4, nonzero, words fit in CNT_W bits
  assign len_ok = (wdata_i[1:0] == 2'b00) && (wdata_i[31:CNT_W+2] == '0)
                  && (wdata_i[CNT_W+1:2] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ptr_o    <= '0;
      rx_ptr_o    <= '0;
      len_words_o <= CNT_W'(1);
      tx_en_o     <= 1'b0;
      rx_en_o     <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_TXPTR && ptr_ok) tx_ptr_o <= wdata_i[ADDR_W-1:0];
      if (addr_i == A_RXPTR && ptr_ok) rx_ptr_o <= wdata_i[ADDR_W-1:0];
      if (addr_i == A_LEN && len_ok) len_words_o <= wdata_i[CNT_W+1:2];
      if (addr_i == A_EN) begin
        tx_en_o <= wdata_i[0];
        rx_en_o <= wdata_i[1];
      end
    end
  end

  assign start_o = we_i && (addr_i == A_START);
  assign stop_o  = we_i && (addr_i == A_STOP);
  assign ev_clr_o[EV_TX]   = we_i && (addr_i == A_CLR_TX) && (wdata_i == '0);
  assign ev_clr_o[EV_RX]   = we_i && (addr_i == A_CLR_RX) && (wdata_i == '0);
  assign ev_clr_o[EV_STOP] = we_i && (addr_i == A_CLR_STOP) && (wdata_i == '0);
  assign mask_set_o = (we_i && addr_i == A_MSET) ? wdata_i[N_EV-1:0] : '0;
  assign mask_clr_o = (we_i && addr_i == A_MCLR) ? wdata_i[N_EV-1:0] : '0;

  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_words_o != '0); // R2
  AST_PTR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ptr_o[1:0] == 2'b00) && (rx_ptr_o[1:0] == 2'b00)); // R1
endmodule

// File: rtl/apdma_event_unit.sv
module apdma_event_unit
  import apdma_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_EV-1:0] ev_set_i,
  input  logic [N_EV-1:0] ev_clr_i,
  input  logic [N_EV-1:0] mask_set_i,
  input  logic [N_EV-1:0] mask_clr_i,
  output logic [N_EV-1:0] ev_o,
  output logic            irq_o
);
  logic [N_EV-1:0] ev_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q   <= (ev_q & ~ev_clr_i) | ev_set_i;  // set wins
      mask_q <= (mask_q | mask_set_i) & ~mask_clr_i;
    end
  end

  assign ev_o  = ev_q;
  assign irq_o = |(ev_q & mask_q);

  AST_EV_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_set_i) |=> ((ev_q & $past(ev_set_i)) == $past(ev_set_i))); // R3
  AST_EV_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~ev_q & $past(ev_q) & ~$past(ev_clr_i)) == '0)); // R6
endmodule

// File: rtl/apdma_stream_seq.sv
module apdma_stream_seq
  import apdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic [31:0]       rx_word_i,
  input  logic [ADDR_W-1:0] tx_ptr_i,
  input  logic [ADDR_W-1:0] rx_ptr_i,
  input  logic [CNT_W-1:0]  len_words_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       tx_word_o,
  output logic              tx_vld_o,
  output logic [N_EV-1:0]   ev_set_o
);
  localparam int unsigned PAD_W = ADDR_W - CNT_W - 2;

  seq_state_e        state_q;
  logic              tx_on_q, rx_on_q, stop_pend_q;
  logic [ADDR_W-1:0] tx_act_q, rx_act_q, offset;
  logic [CNT_W-1:0]  idx_q, cnt_q;
  logic [31:0]       rx_hold_q;
  logic              stop_now, last_word;

  assign stop_now  = (stop_i || stop_pend_q) && (state_q == S_IDLE || state_q == S_WAIT);
  assign last_word = (idx_q == cnt_q - CNT_W'(1));
  assign offset    = {{PAD_W{1'b0}}, idx_q, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      tx_on_q     <= 1'b0;
      rx_on_q     <= 1'b0;
      stop_pend_q <= 1'b0;
      tx_act_q    <= '0;
      rx_act_q    <= '0;
      idx_q       <= '0;
      cnt_q       <= CNT_W'(1);
      rx_hold_q   <= '0;
      tx_word_o   <= '0;
      tx_vld_o    <= 1'b0;
      ev_set_o    <= '0;
    end else begin
      tx_vld_o <= 1'b0;
      ev_set_o <= '0;
      if (stop_i) stop_pend_q <= 1'b1;
      if (stop_now) begin
        state_q           <= S_IDLE;
        stop_pend_q       <= 1'b0;
        tx_on_q           <= 1'b0;
        rx_on_q           <= 1'b0;
        ev_set_o[EV_STOP] <= 1'b1;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            state_q         <= S_WAIT;
            tx_on_q         <= tx_en_i;
            rx_on_q         <= rx_en_i;
            tx_act_q        <= tx_ptr_i;
            rx_act_q        <= rx_ptr_i;
            idx_q           <= '0;
            cnt_q           <= len_words_i;
            ev_set_o[EV_TX] <= tx_en_i;
            ev_set_o[EV_RX] <= rx_en_i;
          end
          S_WAIT: if (tick_i && (tx_on_q || rx_on_q)) begin
            rx_hold_q <= rx_word_i;
            state_q   <= tx_on_q ? S_RD : S_WR;
          end
          S_RD: if (mem_ack_i) begin
            tx_word_o <= mem_rdata_i;
            tx_vld_o  <= 1'b1;
            state_q   <= rx_on_q ? S_WR : S_ADV;
          end
          S_WR: if (mem_ack_i) state_q <= S_ADV;
          S_ADV: begin
            state_q <= S_WAIT;
            if (last_word) begin
              idx_q           <= '0;
              cnt_q           <= len_words_i;
              tx_on_q         <= tx_en_i;
              rx_on_q         <= rx_en_i;
              if (tx_en_i) tx_act_q <= tx_ptr_i;
              if (rx_en_i) rx_act_q <= rx_ptr_i;
              // event marks a pointer taken or a direction finishing
              ev_set_o[EV_TX] <= tx_on_q || tx_en_i;
              ev_set_o[EV_RX] <= rx_on_q || rx_en_i;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = ((state_q == S_RD) ? tx_act_q : rx_act_q) + offset;
  assign mem_wdata_o = rx_hold_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R4
  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R1
  AST_TXVLD_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(mem_req_o && !mem_we_o && mem_ack_i)); // R4
  AST_IDX_IN_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |-> (idx_q < cnt_q)); // R5
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_set_o[EV_STOP] |-> !mem_req_o); // R8
endmodule

// File: rtl/apdma_ptr_ctrl.sv
module apdma_ptr_ctrl
  import apdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frame_tick_i,
  input  logic [31:0]       rx_word_i,
  output logic [31:0]       tx_word_o,
  output logic              tx_word_vld_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [N_EV-1:0]   ev_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] tx_ptr, rx_ptr;
  logic [CNT_W-1:0]  len_words;
  logic              tx_en, rx_en, start, stop;
  logic [N_EV-1:0]   ev_clr, mask_set, mask_clr, ev_set;

  apdma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .tx_ptr_o(tx_ptr), .rx_ptr_o(rx_ptr), .len_words_o(len_words),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .start_o(start), .stop_o(stop),
    .ev_clr_o(ev_clr), .mask_set_o(mask_set), .mask_clr_o(mask_clr)
  );

  apdma_stream_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start), .stop_i(stop), .tick_i(frame_tick_i), .rx_word_i(rx_word_i),
    .tx_ptr_i(tx_ptr), .rx_ptr_i(rx_ptr), .len_words_i(len_words),
    .tx_en_i(tx_en), .rx_en_i(rx_en),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .tx_word_o(tx_word_o), .tx_vld_o(tx_word_vld_o), .ev_set_o(ev_set)
  );

  apdma_event_unit u_ev (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_set_i(ev_set), .ev_clr_i(ev_clr),
    .mask_set_i(mask_set), .mask_clr_i(mask_clr),
    .ev_o(ev_o), .irq_o(irq_o)
  );
endmodule

// File: tb/apdma_ptr_ctrl_tb_top.sv
module apdma_ptr_ctrl_tb_top;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int MAXW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic tick = 1'b0;
  logic [31:0] rx_word = '0;
  logic [31:0] tx_word, mem_wdata, mem_rdata = '0;
  logic tx_vld, mem_req, mem_we, mem_ack = 1'b0, irq;
  logic [AW-1:0] mem_addr;
  logic [2:0] ev;

  always #4 clk = ~clk;

  apdma_ptr_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_tick_i(tick), .rx_word_i(rx_word),
    .tx_word_o(tx_word), .tx_word_vld_o(tx_vld), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .ev_o(ev), .irq_o(irq)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int unsigned w_tx = 0, w_rx = 0, w_len = 1;
  bit w_txen = 0, w_rxen = 0;
  bit m_run = 0, m_txon = 0, m_rxon = 0;
  int unsigned m_txact = 0, m_rxact = 0, m_idx = 0, m_cnt = 1;
  logic [2:0] m_ev = '0, m_mask = '0;
  logic [31:0] q_addr[$], q_dat[$];
  bit q_we[$];
  logic [31:0] exp_txw = '0;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return a ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder with transaction check against model queue
  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      if (q_addr.size() == 0) begin
        chk(0, "R8 unexpected memory request", mem_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea, ed;
        bit ew;
        ea = q_addr.pop_front(); ed = q_dat.pop_front(); ew = q_we.pop_front();
        chk(mem_addr == ea, "R4 R5 address", mem_addr, ea);
        chk(mem_we == ew, "R4 direction", {31'd0, mem_we}, {31'd0, ew});
        if (ew) chk(mem_wdata == ed, "R4 rx write data", mem_wdata, ed);
        else exp_txw = mem_fn(mem_addr);
      end
      mem_rdata <= mem_fn(mem_addr);
      mem_ack <= 1'b1;
    end else mem_ack <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && tx_vld) chk(tx_word == exp_txw, "R4 tx word", tx_word, exp_txw);
    if (rst_n) chk(irq == |(ev & m_mask), "R7 irq per cycle", {31'd0, irq}, {31'd0, |(ev & m_mask)});
  end

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd0: if (d[1:0] == 0) w_tx = d;
      4'd1: if (d[1:0] == 0) w_rx = d;
      4'd2: if (d[1:0] == 0 && (d >> 2) != 0 && (d >> 2) <= MAXW) w_len = d >> 2;
      4'd3: begin w_txen = d[0]; w_rxen = d[1]; end
      4'd4: if (!m_run) begin
        m_run = 1; m_txon = w_txen; m_rxon = w_rxen;
        m_txact = w_tx; m_rxact = w_rx; m_idx = 0; m_cnt = w_len;
        if (w_txen) m_ev[0] = 1;
        if (w_rxen) m_ev[1] = 1;
      end
      4'd5: begin m_run = 0; m_txon = 0; m_rxon = 0; m_ev[2] = 1; end
      4'd6: if (d == 0) m_ev[0] = 0;
      4'd7: if (d == 0) m_ev[1] = 0;
      4'd8: if (d == 0) m_ev[2] = 0;
      4'd9: m_mask = m_mask | d[2:0];
      4'd10: m_mask = m_mask & ~d[2:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    model_write(a, d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_tick(input logic [31:0] d);
    if (m_run && (m_txon || m_rxon)) begin
      if (m_txon) begin q_addr.push_back(m_txact + 4 * m_idx); q_we.push_back(0); q_dat.push_back('0); end
      if (m_rxon) begin q_addr.push_back(m_rxact + 4 * m_idx); q_we.push_back(1); q_dat.push_back(d); end
      m_idx++;
      if (m_idx == m_cnt) begin
        m_idx = 0; m_cnt = w_len;
        if (m_txon || w_txen) m_ev[0] = 1;
        if (m_rxon || w_rxen) m_ev[1] = 1;
        m_txon = w_txen; m_rxon = w_rxen;
        if (w_txen) m_txact = w_tx;
        if (w_rxen) m_rxact = w_rx;
      end
    end
    @(negedge clk);
    tick = 1; rx_word = d;
    @(negedge clk);
    tick = 0;
    repeat (10) @(negedge clk);
    chk(q_addr.size() == 0, "R4 all predicted ops issued", q_addr.size(), 0);
  endtask

  task automatic chk_ev(input string tag);
    repeat (3) @(negedge clk);
    chk(ev == m_ev, tag, {29'd0, ev}, {29'd0, m_ev});
    chk(irq == |(m_ev & m_mask), tag, {31'd0, irq}, {31'd0, |(m_ev & m_mask)});
  endtask

  task automatic clr_all();
    wr(4'd6, 0); wr(4'd7, 0); wr(4'd8, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(mem_req == 0, "R10 no request", {31'd0, mem_req}, 0);
    chk(ev == 0, "R10 events clear", {29'd0, ev}, 0);
    chk(irq == 0, "R10 irq low", {31'd0, irq}, 0);
    chk(tx_vld == 0, "R10 no tx word", {31'd0, tx_vld}, 0);

    // R3 start with both directions, 3-word buffers
    wr(4'd2, 12); wr(4'd0, 32'h1000); wr(4'd1, 32'h2000);
    wr(4'd3, 3); wr(4'd9, 7); wr(4'd4, 0);
    chk_ev("R3 start events");
    // R6 nonzero clear ignored, zero clears
    wr(4'd6, 5);
    chk_ev("R6 nonzero clear ignored");
    clr_all();
    chk_ev("R6 zero clear");

    // R2 bad lengths ignored; R1 misaligned pointer ignored
    wr(4'd2, 14); wr(4'd2, 0); wr(4'd2, (MAXW + 1) * 4);
    do_tick(32'hAAAA_0001);
    do_tick(32'hAAAA_0002);
    wr(4'd0, 32'h3000); wr(4'd0, 32'h3002);
    wr(4'd1, 32'h2006);
    do_tick(32'hAAAA_0003);
    chk_ev("R5 boundary events");
    clr_all();

    // second buffer: tx new pointer, rx replay, length unchanged (R2)
    wr(4'd2, 8);
    do_tick(32'hBBBB_0001);
    do_tick(32'hBBBB_0002);
    chk_ev("R2 no early boundary");
    do_tick(32'hBBBB_0003);
    chk_ev("R5 replay boundary");
    clr_all();

    // third buffer 2 words; disable tx mid-buffer (R9)
    do_tick(32'hCCCC_0001);
    wr(4'd3, 2);
    do_tick(32'hCCCC_0002);
    chk_ev("R9 final tx event");
    clr_all();
    do_tick(32'hDDDD_0001);
    do_tick(32'hDDDD_0002);
    chk_ev("R9 rx only after disable");

    // R7 mask control
    wr(4'd10, 2);
    chk_ev("R7 masked rx event");
    wr(4'd9, 2);
    chk_ev("R7 unmasked rx event");
    clr_all();

    // R8 stop
    wr(4'd5, 0);
    chk_ev("R8 stopped event");
    do_tick(32'hEEEE_0001);
    chk(mem_req == 0, "R8 quiet after stop", {31'd0, mem_req}, 0);
    wr(4'd10, 4);
    chk_ev("R7 stop masked");

    chk(q_addr.size() == 0, "R4 queue drained", q_addr.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule